// File: doc/BRIEF.md
# Configuration Descriptor Set Parser

This block takes in, one byte per valid cycle, the byte stream of a USB configuration descriptor set, and marks the final byte with a last flag. It walks the stream one descriptor at a time. The first byte of each descriptor gives that descriptor's length, and the second gives its type. The length tells the walker where the next descriptor starts. From the configuration header it decodes the declared total length and the interface count. From each interface descriptor it decodes the number, the alternate setting, the class and the endpoint count. From each endpoint descriptor it decodes the number, the direction, the transfer type, the 16-bit maximum packet size and the polling interval. Interfaces and endpoints go into two register tables that a neighbouring controller reads directly.

Class-specific descriptors (type 0x21) and any type the parser does not know are passed over by their length, and their content is not read. Three sticky flags report problems with the stream. The first is a descriptor that claims a length below two. The second is a byte count that disagrees with the declared total. The third is more endpoints than the table can hold. All results stay valid after the last byte until the first byte of the next stream. That byte clears the results and starts a new walk.

Top module: `cfg_desc_parser`

## Requirements
- R1: After reset, every output is zero.
- R2: Each descriptor starts with a length byte and then a type byte, and the next descriptor begins right after length bytes. Type 0x21 and any type other than 0x02, 0x04 and 0x05 is skipped by its length and has no effect on the tables, counts or fields.
- R3: In a type 0x02 descriptor, bytes 2 and 3 give `total_len` (low byte first) and byte 4 gives `num_ifc`.
- R4: Each type 0x04 descriptor adds one to `ifc_seen`. While fewer than IFC_MAX interfaces are stored, it writes slot `ifc_seen` of `ifc_table` with {byte 2 number [31:24], byte 3 alternate setting [23:16], byte 5 class [15:8], byte 4 endpoint count [7:0]}. Interfaces past the table size are counted only.
- R5: Each type 0x05 descriptor adds one to `ep_seen` and writes slot `ep_seen` of `ep_table`. Each slot is 39 bits: {interface class [38:31], byte 6 interval [30:23], bytes 4–5 max packet size [22:7] (low byte first), byte 3 bits 1:0 transfer type [6:5], byte 2 bit 7 direction IN [4], byte 2 bits 3:0 endpoint number [3:0]}. Slot k sits at bits [k*39 +: 39].
- R6: Endpoints past EP_MAX are counted in `ep_seen` but not stored, and they set `ovf_err`.
- R7: A length byte below 2 at the start of a descriptor sets `fmt_err`. No later byte of that stream is decoded, but bytes are still counted.
- R8: On the last byte, `len_err` is set when the number of bytes received differs from `total_len`.
- R9: `done` rises in the cycle after the last byte is accepted. The next valid byte after `done` starts a new stream and clears every result first.
- R10: A cycle without `in_valid` changes no output.
- R11: The interface class stored with an endpoint is the class of the most recent interface descriptor, or 0 if the stream has had none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A stream byte is present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | This byte ends the stream |
| done | output | 1 | Stream complete, results valid |
| fmt_err | output | 1 | Descriptor length below 2 seen |
| len_err | output | 1 | Byte count differs from declared total |
| ovf_err | output | 1 | Endpoint table overflowed |
| total_len | output | 16 | Declared total length |
| num_ifc | output | 8 | Declared interface count |
| ifc_seen | output | 8 | Interface descriptors found |
| ep_seen | output | 8 | Endpoint descriptors found |
| ep_table | output | EP_MAX*39 | Endpoint entries |
| ifc_table | output | IFC_MAX*32 | Interface entries |

## Verification
If the byte position inside a descriptor goes wrong, the walker loses its framing. Every later descriptor is then misread, and the damage shows up in the stored entries and counts at the end of the same stream. Random descriptor mixes with skipped records of varied lengths, including the two-byte minimum, show this. A wrong interface class register, or a table index that is off by one, puts a bad value in a specific table slot. That slot is compared bit for bit once `done` rises. Errors in the flags or in clearing between streams show up on the first stream after the fault. Results are compared in every stream, and again after idle cycles.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

    localparam logic [7:0] TYPE_CFG = 8'h02;
    localparam logic [7:0] TYPE_IFC = 8'h04;
    localparam logic [7:0] TYPE_EP  = 8'h05;

    typedef struct packed {
        logic [7:0]  ifc_class;
        logic [7:0]  interval;
        logic [15:0] max_pkt;
        logic [1:0]  xfer;
        logic        dir_in;
        logic [3:0]  ep_num;
    } ep_entry_t;

    typedef struct packed {
        logic [7:0] ifc_num;
        logic [7:0] alt;
        logic [7:0] ifc_class;
        logic [7:0] n_eps;
    } ifc_entry_t;

    localparam int EP_W  = $bits(ep_entry_t);
    localparam int IFC_W = $bits(ifc_entry_t);

endpackage

// File: rtl/cdp_walker.sv
module cdp_walker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid_i,
    input  logic [7:0]  in_data_i,
    input  logic        in_last_i,
    output logic        step_o,
    output logic        restart_o,
    output logic        last_o,
    output logic [7:0]  pos_o,
    output logic [7:0]  dtype_o,
    output logic [15:0] cnt_o,
    output logic        fmt_err_o,
    output logic        done_o
);
    typedef struct packed {
        logic [7:0]  pos;
        logic [7:0]  len;
        logic [7:0]  dtype;
        logic [15:0] cnt;
        logic        halt;
        logic        fmt_err;
        logic        done;
    } walk_t;

    walk_t q, d, b;
    logic  step;
    logic  restart;

    always_comb begin
        restart = in_valid_i && q.done;
        b       = restart ? '0 : q;
        d       = b;
        step    = 1'b0;
        if (in_valid_i) begin
            d.cnt  = b.cnt + 16'd1;
            d.done = in_last_i;
            if (!b.halt) begin
                if (b.pos == 8'd0) begin
                    if (in_data_i < 8'd2) begin
                        d.fmt_err = 1'b1;
                        d.halt    = 1'b1;
                    end else begin
                        d.len = in_data_i;
                        d.pos = 8'd1;
                        step  = 1'b1;
                    end
                end else begin
                    step = 1'b1;
                    if (b.pos == 8'd1) begin
                        d.dtype = in_data_i;
                    end
                    d.pos = (b.pos == b.len - 8'd1) ? 8'd0 : b.pos + 8'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign step_o    = step;
    assign restart_o = restart;
    assign last_o    = in_valid_i && in_last_i;
    assign pos_o     = b.pos;
    assign dtype_o   = b.dtype;
    assign cnt_o     = d.cnt;
    assign fmt_err_o = q.fmt_err;
    assign done_o    = q.done;
endmodule

// File: rtl/cdp_decoder.sv
module cdp_decoder
    import cdp_pkg::*;
#(
    parameter int EP_MAX  = 4,
    parameter int IFC_MAX = 4,
    parameter int EAW     = 2,
    parameter int IAW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic             last_i,
    input  logic [7:0]       pos_i,
    input  logic [7:0]       dtype_i,
    input  logic [7:0]       data_i,
    input  logic [15:0]      cnt_i,
    output logic [15:0]      total_len_o,
    output logic [7:0]       num_ifc_o,
    output logic [7:0]       ifc_seen_o,
    output logic [7:0]       ep_seen_o,
    output logic             len_err_o,
    output logic             ovf_err_o,
    output logic             ep_we_o,
    output logic [EAW-1:0]   ep_waddr_o,
    output ep_entry_t        ep_wdata_o,
    output logic             ifc_we_o,
    output logic [IAW-1:0]   ifc_waddr_o,
    output ifc_entry_t       ifc_wdata_o
);
    localparam logic [7:0] EP_LIM  = 8'(EP_MAX);
    localparam logic [7:0] IFC_LIM = 8'(IFC_MAX);

    typedef struct packed {
        logic [15:0] total_len;
        logic [7:0]  num_ifc;
        logic [7:0]  ifc_seen;
        logic [7:0]  ep_seen;
        logic [7:0]  cur_class;
        logic [7:0]  ifc_num;
        logic [7:0]  ifc_alt;
        logic [7:0]  ifc_neps;
        logic        ep_dir;
        logic [3:0]  ep_num;
        logic [1:0]  ep_xfer;
        logic [15:0] ep_mps;
        logic        len_err;
        logic        ovf_err;
    } dec_t;

    dec_t q, d, b;

    always_comb begin
        b           = restart_i ? '0 : q;
        d           = b;
        ep_we_o     = 1'b0;
        ep_waddr_o  = b.ep_seen[EAW-1:0];
        ep_wdata_o  = '0;
        ifc_we_o    = 1'b0;
        ifc_waddr_o = b.ifc_seen[IAW-1:0];
        ifc_wdata_o = '0;
        if (step_i && pos_i >= 8'd2) begin
            unique case (dtype_i)
                TYPE_CFG: begin
                    case (pos_i)
                        8'd2: d.total_len[7:0]  = data_i;
                        8'd3: d.total_len[15:8] = data_i;
                        8'd4: d.num_ifc         = data_i;
                        default: ;
                    endcase
                end
                TYPE_IFC: begin
                    case (pos_i)
                        8'd2: d.ifc_num  = data_i;
                        8'd3: d.ifc_alt  = data_i;
                        8'd4: d.ifc_neps = data_i;
                        8'd5: begin
                            d.cur_class = data_i;
                            ifc_we_o    = (b.ifc_seen < IFC_LIM);
                            ifc_wdata_o = '{ifc_num: b.ifc_num, alt: b.ifc_alt,
                                            ifc_class: data_i, n_eps: b.ifc_neps};
                            if (b.ifc_seen != 8'hFF) d.ifc_seen = b.ifc_seen + 8'd1;
                        end
                        default: ;
                    endcase
                end
                TYPE_EP: begin
                    case (pos_i)
                        8'd2: begin
                            d.ep_dir = data_i[7];
                            d.ep_num = data_i[3:0];
                        end
                        8'd3: d.ep_xfer       = data_i[1:0];
                        8'd4: d.ep_mps[7:0]   = data_i;
                        8'd5: d.ep_mps[15:8]  = data_i;
                        8'd6: begin
                            ep_we_o    = (b.ep_seen < EP_LIM);
                            ep_wdata_o = '{ifc_class: b.cur_class, interval: data_i,
                                           max_pkt: b.ep_mps, xfer: b.ep_xfer,
                                           dir_in: b.ep_dir, ep_num: b.ep_num};
                            if (b.ep_seen >= EP_LIM) d.ovf_err = 1'b1;
                            if (b.ep_seen != 8'hFF) d.ep_seen = b.ep_seen + 8'd1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
        if (last_i) begin
            d.len_err = (cnt_i != d.total_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign total_len_o = q.total_len;
    assign num_ifc_o   = q.num_ifc;
    assign ifc_seen_o  = q.ifc_seen;
    assign ep_seen_o   = q.ep_seen;
    assign len_err_o   = q.len_err;
    assign ovf_err_o   = q.ovf_err;
endmodule

// File: rtl/cdp_regtable.sv
module cdp_regtable #(
    parameter int W  = 8,
    parameter int N  = 4,
    parameter int AW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           we_i,
    input  logic [AW-1:0]  waddr_i,
    input  logic [W-1:0]   wdata_i,
    output logic [N*W-1:0] table_o
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_i) slot_d = '0;
            else if (we_i && waddr_i == AW'(g)) slot_d = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign table_o[g*W +: W] = slot_q;
    end
endmodule

// File: rtl/cfg_desc_parser.sv
module cfg_desc_parser
    import cdp_pkg::*;
#(
    parameter int EP_MAX  = 4,
    parameter int IFC_MAX = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    input  logic                    in_last,
    output logic                    done,
    output logic                    fmt_err,
    output logic                    len_err,
    output logic                    ovf_err,
    output logic [15:0]             total_len,
    output logic [7:0]              num_ifc,
    output logic [7:0]              ifc_seen,
    output logic [7:0]              ep_seen,
    output logic [EP_MAX*EP_W-1:0]  ep_table,
    output logic [IFC_MAX*IFC_W-1:0] ifc_table
);
    localparam int EAW = (EP_MAX  > 1) ? $clog2(EP_MAX)  : 1;
    localparam int IAW = (IFC_MAX > 1) ? $clog2(IFC_MAX) : 1;

    logic           step, restart, last;
    logic [7:0]     pos, dtype;
    logic [15:0]    cnt;
    logic           ep_we, ifc_we;
    logic [EAW-1:0] ep_waddr;
    logic [IAW-1:0] ifc_waddr;
    ep_entry_t      ep_wdata;
    ifc_entry_t     ifc_wdata;

    cdp_walker u_walk (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
        .step_o(step), .restart_o(restart), .last_o(last),
        .pos_o(pos), .dtype_o(dtype), .cnt_o(cnt),
        .fmt_err_o(fmt_err), .done_o(done)
    );

    cdp_decoder #(.EP_MAX(EP_MAX), .IFC_MAX(IFC_MAX), .EAW(EAW), .IAW(IAW)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .step_i(step), .restart_i(restart), .last_i(last),
        .pos_i(pos), .dtype_i(dtype), .data_i(in_data), .cnt_i(cnt),
        .total_len_o(total_len), .num_ifc_o(num_ifc),
        .ifc_seen_o(ifc_seen), .ep_seen_o(ep_seen),
        .len_err_o(len_err), .ovf_err_o(ovf_err),
        .ep_we_o(ep_we), .ep_waddr_o(ep_waddr), .ep_wdata_o(ep_wdata),
        .ifc_we_o(ifc_we), .ifc_waddr_o(ifc_waddr), .ifc_wdata_o(ifc_wdata)
    );

    cdp_regtable #(.W(EP_W), .N(EP_MAX), .AW(EAW)) u_ep_tab (
        .clk(clk), .rst_n(rst_n), .clr_i(restart),
        .we_i(ep_we), .waddr_i(ep_waddr), .wdata_i(ep_wdata),
        .table_o(ep_table)
    );

    cdp_regtable #(.W(IFC_W), .N(IFC_MAX), .AW(IAW)) u_ifc_tab (
        .clk(clk), .rst_n(rst_n), .clr_i(restart),
        .we_i(ifc_we), .waddr_i(ifc_waddr), .wdata_i(ifc_wdata),
        .table_o(ifc_table)
    );
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
    parameter int EP_MAX = 4,
    parameter int EPT_W  = 156,
    parameter int IFT_W  = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             done,
    input logic             fmt_err,
    input logic             len_err,
    input logic             ovf_err,
    input logic [7:0]       ep_seen,
    input logic [7:0]       ifc_seen,
    input logic [EPT_W-1:0] ep_table,
    input logic [IFT_W-1:0] ifc_table
);
    localparam logic [7:0] LIM = 8'(EP_MAX);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid && in_last));

    assert_fmt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fmt_err) |-> $past(in_valid && done));

    assert_ovf_only_past_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> (ep_seen > LIM));

    assert_ovf_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_seen > LIM) |-> ovf_err);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ep_table) && $stable(ifc_table) && $stable(ep_seen)
                       && $stable(ifc_seen) && $stable(done)));

    assert_lenerr_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> $past(in_valid && in_last));
endmodule

bind cfg_desc_parser cdp_checker #(
    .EP_MAX(EP_MAX),
    .EPT_W(EP_MAX * cdp_pkg::EP_W),
    .IFT_W(IFC_MAX * cdp_pkg::IFC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .done(done), .fmt_err(fmt_err), .len_err(len_err), .ovf_err(ovf_err),
    .ep_seen(ep_seen), .ifc_seen(ifc_seen),
    .ep_table(ep_table), .ifc_table(ifc_table)
);

// File: tb/sim_cfg_desc_parser.sv
`timescale 1ns/1ps
module sim_cfg_desc_parser;
    localparam int EPM = 4;
    localparam int IFM = 4;
    localparam int EW  = 39;
    localparam int IW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic in_last = 1'b0;
    logic done, fmt_err, len_err, ovf_err;
    logic [15:0] total_len;
    logic [7:0] num_ifc, ifc_seen, ep_seen;
    logic [EPM*EW-1:0] ep_table;
    logic [IFM*IW-1:0] ifc_table;

    always #2.5 clk = ~clk;

    cfg_desc_parser #(.EP_MAX(EPM), .IFC_MAX(IFM)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .done(done), .fmt_err(fmt_err), .len_err(len_err),
        .ovf_err(ovf_err), .total_len(total_len), .num_ifc(num_ifc),
        .ifc_seen(ifc_seen), .ep_seen(ep_seen), .ep_table(ep_table),
        .ifc_table(ifc_table)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] sbuf [0:1023];
    int slen;
    int cfg_at;
    logic halted;
    logic [15:0] e_total;
    logic [7:0] e_nifc, e_ifc_seen, e_ep_seen, e_class;
    logic e_fmt, e_len, e_ovf;
    logic [EPM*EW-1:0] e_ept;
    logic [IFM*IW-1:0] e_ift;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic new_stream();
        slen = 0; cfg_at = -1; halted = 1'b0;
        e_total = 16'd0; e_nifc = 8'd0; e_ifc_seen = 8'd0; e_ep_seen = 8'd0;
        e_class = 8'd0; e_fmt = 1'b0; e_len = 1'b0; e_ovf = 1'b0;
        e_ept = '0; e_ift = '0;
    endtask

    task automatic push(input logic [7:0] v);
        sbuf[slen] = v;
        slen++;
    endtask

    task automatic add_cfg(input logic [7:0] nifc);
        cfg_at = slen;
        push(8'd9); push(8'h02); push(8'h00); push(8'h00); push(nifc);
        for (int i = 0; i < 4; i++) push(8'($urandom));
        if (!halted) e_nifc = nifc;
    endtask

    task automatic add_ifc(input logic [7:0] num, input logic [7:0] alt,
                           input logic [7:0] neps, input logic [7:0] cls);
        push(8'd9); push(8'h04); push(num); push(alt); push(neps); push(cls);
        for (int i = 0; i < 3; i++) push(8'($urandom));
        if (!halted) begin
            if (e_ifc_seen < IFM) e_ift[e_ifc_seen*IW +: IW] = {num, alt, cls, neps};
            e_ifc_seen++;
            e_class = cls;
        end
    endtask

    task automatic add_ep(input logic [7:0] addr, input logic [7:0] attr,
                          input logic [15:0] mps, input logic [7:0] ival);
        push(8'd7); push(8'h05); push(addr); push(attr);
        push(mps[7:0]); push(mps[15:8]); push(ival);
        if (!halted) begin
            if (e_ep_seen < EPM)
                e_ept[e_ep_seen*EW +: EW] = {e_class, ival, mps, attr[1:0], addr[7], addr[3:0]};
            else
                e_ovf = 1'b1;
            e_ep_seen++;
        end
    endtask

    task automatic add_skip(input logic [7:0] typ, input int len);
        push(8'(len)); push(typ);
        for (int i = 2; i < len; i++) push(8'($urandom));
    endtask

    task automatic add_bad();
        push(8'($urandom_range(0, 1)));
        if (!halted) e_fmt = 1'b1;
        halted = 1'b1;
    endtask

    task automatic finish_stream(input bit corrupt);
        logic [15:0] decl;
        decl = 16'(slen) + (corrupt ? 16'd1 : 16'd0);
        if (cfg_at >= 0) begin
            sbuf[cfg_at+2] = decl[7:0];
            sbuf[cfg_at+3] = decl[15:8];
            e_total = decl;
        end
        e_len = (e_total != 16'(slen));
    endtask

    task automatic run_stream(input int gapmax);
        for (int i = 0; i < slen; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = sbuf[i]; in_last = (i == slen - 1);
            if (i != slen - 1) begin
                repeat ($urandom_range(0, gapmax)) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_last = 1'b0; in_data = 8'($urandom);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({"R9 done ", tag}, 256'(done), 256'(1'b1));
        chk({"R3 total_len ", tag}, 256'(total_len), 256'(e_total));
        chk({"R3 num_ifc ", tag}, 256'(num_ifc), 256'(e_nifc));
        chk({"R4 ifc_seen ", tag}, 256'(ifc_seen), 256'(e_ifc_seen));
        chk({"R4 ifc_table ", tag}, 256'(ifc_table), 256'(e_ift));
        chk({"R5 ep_seen ", tag}, 256'(ep_seen), 256'(e_ep_seen));
        chk({"R5 R11 ep_table ", tag}, 256'(ep_table), 256'(e_ept));
        chk({"R6 ovf_err ", tag}, 256'(ovf_err), 256'(e_ovf));
        chk({"R7 fmt_err ", tag}, 256'(fmt_err), 256'(e_fmt));
        chk({"R8 len_err ", tag}, 256'(len_err), 256'(e_len));
    endtask

    task automatic gen_random();
        int ni;
        new_stream();
        add_cfg(8'($urandom_range(0, 3)));
        ni = $urandom_range(0, 5);
        for (int k = 0; k < ni; k++) begin
            int ne;
            if ($urandom_range(0, 2) == 0) add_skip(8'h21, 9);
            add_ifc(8'(k), 8'($urandom_range(0, 1)), 8'($urandom_range(0, 3)),
                    ($urandom_range(0, 1) == 1) ? 8'h03 : 8'hFF);
            ne = $urandom_range(0, 3);
            for (int e = 0; e < ne; e++) begin
                if ($urandom_range(0, 3) == 0) add_skip(8'h30, $urandom_range(2, 8));
                add_ep({1'($urandom), 3'($urandom), 4'($urandom_range(1, 15))},
                       8'($urandom), 16'($urandom), 8'($urandom));
            end
        end
        finish_stream($urandom_range(0, 3) == 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        chk("R1 done", 256'(done), 256'(0));
        chk("R1 flags", 256'({fmt_err, len_err, ovf_err}), 256'(0));
        chk("R1 counts", 256'({total_len, num_ifc, ifc_seen, ep_seen}), 256'(0));
        chk("R1 tables", 256'({ep_table, ifc_table}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R8: header alone, exact length
        new_stream(); add_cfg(8'd0); finish_stream(1'b0);
        run_stream(0); check_all("cfg only");

        // R11: endpoint before any interface carries class 0
        new_stream(); add_cfg(8'd1);
        add_ep(8'h81, 8'h03, 16'h0040, 8'h01);
        add_ifc(8'd0, 8'd0, 8'd1, 8'h03);
        add_ep(8'h02, 8'h03, 16'h0040, 8'h0A);
        finish_stream(1'b0);
        run_stream(1); check_all("class order");

        // R2: minimal two-byte unknown record and class record are skipped
        new_stream(); add_cfg(8'd1);
        add_skip(8'h0B, 2); add_ifc(8'd3, 8'd1, 8'd1, 8'hFF);
        add_skip(8'h21, 9); add_skip(8'h05 ^ 8'h40, 2);
        add_ep(8'h01, 8'h02, 16'h0200, 8'h00);
        finish_stream(1'b0);
        run_stream(2); check_all("skip");

        // R6: more endpoints than slots
        new_stream(); add_cfg(8'd1); add_ifc(8'd0, 8'd0, 8'd6, 8'h03);
        for (int e = 0; e < 6; e++) add_ep(8'(8'h81 + e), 8'h03, 16'(e * 8), 8'(e));
        finish_stream(1'b0);
        run_stream(0); check_all("overflow");

        // R10: idle cycles leave the results alone
        repeat (7) @(negedge clk);
        check_all("idle hold");

        // R7: bad length halts decoding; endpoint-like bytes after it are ignored
        new_stream(); add_cfg(8'd1); add_ifc(8'd0, 8'd0, 8'd1, 8'hFF);
        add_bad(); add_ep(8'h83, 8'h03, 16'h0008, 8'h04);
        finish_stream(1'b0);
        run_stream(1); check_all("format");

        // R8: no header at all
        new_stream(); add_ifc(8'd0, 8'd0, 8'd0, 8'h03); finish_stream(1'b0);
        run_stream(0); check_all("no header");

        for (int r = 0; r < 40; r++) begin
            gen_random();
            run_stream(r % 3);
            check_all($sformatf("random %0d", r));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule